// File: doc/BRIEF.md
# Sixteen-Way Named Thread Barrier

This block gives a cooperative thread group a set of independent, numbered synchronization barriers. A warp reaches a barrier by sending one request beat. The beat names a barrier (ID 0 when no ID is given), may carry a thread count, and identifies the warp. The block holds each arriving warp until enough threads have reached that barrier. It then releases every warp waiting on it in the same cycle and makes the barrier ready for its next use in that same cycle.

With an explicit count, a barrier completes once that many threads have arrived. Without one, it completes once every warp that has not exited has arrived. Each arrival counts for one full warp of threads. The block reports two kinds of misuse. The first is a thread count that is zero or is not a whole number of warps. The second is a second count given for a barrier that already has a different count pending. In both cases the offending arrival is dropped.

The request port is valid/ready, and ready is always high. The block takes one arrival per cycle and never applies back-pressure. The exit vector, the release vector and the error flags are plain level or pulse signals.

Top module: `nb_barrier_unit`

## Requirements
- R1: After reset, release_warps is all zero, both error flags are low, and every barrier is empty.
- R2: A barrier given an explicit count N (a multiple of WARP_SIZE) releases on the arrival that brings it to N threads. Each arrival adds WARP_SIZE. The release is a one-cycle pulse on release_warps, in the cycle after the edge that takes the completing arrival, with a bit set for every warp waiting on that barrier.
- R3: An arrival with arr_cnt_given high and arr_thr_cnt zero or not divisible by WARP_SIZE raises err_not_multiple for one cycle after its edge. The arrival is discarded and no barrier changes.
- R4: With arr_cnt_given low, the barrier needs WARP_SIZE threads for each warp whose warp_exit bit is low.
- R5: When a warp_exit bit goes high, the requirement of all-live barriers drops at once. A barrier whose waiters now meet it releases one cycle later, with no further arrival.
- R6: With arr_id_given low, the arrival goes to barrier 0 and arr_bar_id is ignored.
- R7: Arrivals on one barrier ID never complete or release another barrier.
- R8: A barrier re-arms with no delay. An arrival taken in the cycle its previous use completes counts toward the new use and is not released with the old waiters.
- R9: An arrival on a barrier that has waiters, but whose mode or explicit count differs from the pending one, raises err_count_clash for one cycle and is discarded.
- R10: arr_ready is always high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arr_valid | input | 1 | Arrival beat valid |
| arr_ready | output | 1 | Always 1; no back-pressure |
| arr_id_given | input | 1 | arr_bar_id is meaningful; low selects barrier 0 |
| arr_bar_id | input | $clog2(NUM_BARS) | Barrier number |
| arr_cnt_given | input | 1 | Explicit thread count present; low means all live warps |
| arr_thr_cnt | input | $clog2(NUM_WARPS*WARP_SIZE+1) | Explicit thread count |
| arr_warp | input | $clog2(NUM_WARPS) | Arriving warp number |
| warp_exit | input | NUM_WARPS | Level, one bit per warp: warp has exited |
| release_warps | output | NUM_WARPS | One-cycle pulse per released warp |
| err_not_multiple | output | 1 | Pulse: bad explicit count |
| err_count_clash | output | 1 | Pulse: conflicting count on a busy barrier |

## Verification
The bench builds the block with all 16 barriers, WARP_SIZE of 32, and NUM_WARPS reduced to 4, so every barrier and every participant count from one to four warps can be swept in turn. With four warps, the all-live requirement can also be lowered to each smaller size through warp_exit. Re-arming within the release cycle, clashing counts, and bad counts each take only a few beats to reach, and the expected release masks are simple bit ranges.

// File: rtl/nb_pkg.sv
package nb_pkg;
  typedef enum logic {
    NB_EXPLICIT = 1'b0,
    NB_ALL_LIVE = 1'b1
  } nb_mode_e;
endpackage

// File: rtl/nb_req_decode.sv
module nb_req_decode
  import nb_pkg::*;
#(
  parameter int NUM_BARS  = 16,
  parameter int WARP_SIZE = 32,
  parameter int ID_W      = 4,
  parameter int CNT_W     = 11
) (
  input  logic             id_given,
  input  logic [ID_W-1:0]  bar_id,
  input  logic             cnt_given,
  input  logic [CNT_W-1:0] thr_cnt,
  output logic [ID_W-1:0]  sel_id,
  output nb_mode_e         mode,
  output logic [CNT_W-1:0] need,
  output logic             bad
);
  localparam logic [CNT_W-1:0] WS_C = CNT_W'(WARP_SIZE);

  always_comb begin
    sel_id = id_given ? bar_id : '0;
    mode   = cnt_given ? NB_EXPLICIT : NB_ALL_LIVE;
    need   = cnt_given ? thr_cnt : '0;
    bad    = cnt_given && ((thr_cnt == '0) || ((thr_cnt % WS_C) != '0));
  end
endmodule

// File: rtl/nb_slot.sv
module nb_slot
  import nb_pkg::*;
#(
  parameter int NUM_WARPS = 32,
  parameter int WARP_SIZE = 32,
  parameter int SUM_W     = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit,
  input  nb_mode_e             req_mode,
  input  logic [SUM_W-1:0]     req_need,
  input  logic [NUM_WARPS-1:0] req_warp_1h,
  input  logic [SUM_W-1:0]     live_need,
  output logic                 done,
  output logic [NUM_WARPS-1:0] waiting,
  output logic                 clash
);
  localparam logic [SUM_W-1:0] STEP = SUM_W'(WARP_SIZE);

  logic [SUM_W-1:0]     arrived_q;
  logic [SUM_W-1:0]     need_q;
  nb_mode_e             mode_q;
  logic [NUM_WARPS-1:0] wait_q;
  logic                 busy, open, take;
  logic [SUM_W-1:0]     target;

  always_comb begin
    busy   = arrived_q != '0;
    target = (mode_q == NB_ALL_LIVE) ? live_need : need_q;
    done   = busy && (arrived_q >= target);
    open   = busy && !done;
    clash  = hit && open &&
             ((mode_q != req_mode) || (req_mode == NB_EXPLICIT && need_q != req_need));
    take   = hit && !clash;
  end

  assign waiting = wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arrived_q <= '0;
      need_q    <= '0;
      mode_q    <= NB_EXPLICIT;
      wait_q    <= '0;
    end else begin
      if (take) begin
        arrived_q <= (done ? '0 : arrived_q) + STEP;
        wait_q    <= (done ? '0 : wait_q) | req_warp_1h;
        if (!open) begin
          mode_q <= req_mode;
          need_q <= req_need;
        end
      end else if (done) begin
        arrived_q <= '0;
        wait_q    <= '0;
      end
    end
  end

  // R2: a completed use leaves the barrier empty
  p_clear_after_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done && !take |=> arrived_q == '0);
  // R2: each accepted arrival adds one warp of threads
  p_step_per_arrival_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && !done |=> arrived_q == $past(arrived_q) + STEP);
  // R8: arrival in the completing cycle starts the next use alone
  p_rearm_fresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take && done |=> arrived_q == STEP);
endmodule

// File: rtl/nb_barrier_unit.sv
module nb_barrier_unit
  import nb_pkg::*;
#(
  parameter int NUM_BARS  = 16,
  parameter int NUM_WARPS = 32,
  parameter int WARP_SIZE = 32,
  localparam int ID_W     = $clog2(NUM_BARS),
  localparam int WID_W    = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
  localparam int CNT_W    = $clog2(NUM_WARPS*WARP_SIZE+1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arr_valid,
  output logic                 arr_ready,
  input  logic                 arr_id_given,
  input  logic [ID_W-1:0]      arr_bar_id,
  input  logic                 arr_cnt_given,
  input  logic [CNT_W-1:0]     arr_thr_cnt,
  input  logic [WID_W-1:0]     arr_warp,
  input  logic [NUM_WARPS-1:0] warp_exit,
  output logic [NUM_WARPS-1:0] release_warps,
  output logic                 err_not_multiple,
  output logic                 err_count_clash
);
  localparam int SUM_W = CNT_W + 1;

  logic [ID_W-1:0]      sel_id;
  nb_mode_e             req_mode;
  logic [CNT_W-1:0]     req_need;
  logic                 req_bad;
  logic [NUM_WARPS-1:0] warp_1h;
  logic [SUM_W-1:0]     live_need;
  logic [NUM_BARS-1:0]  slot_done, slot_clash, slot_hit;
  logic [NUM_WARPS-1:0] slot_wait [NUM_BARS];
  logic [NUM_WARPS-1:0] rel_d;

  assign arr_ready = 1'b1;

  nb_req_decode #(
    .NUM_BARS(NUM_BARS), .WARP_SIZE(WARP_SIZE), .ID_W(ID_W), .CNT_W(CNT_W)
  ) u_dec (
    .id_given(arr_id_given), .bar_id(arr_bar_id),
    .cnt_given(arr_cnt_given), .thr_cnt(arr_thr_cnt),
    .sel_id(sel_id), .mode(req_mode), .need(req_need), .bad(req_bad)
  );

  always_comb begin
    warp_1h   = '0;
    warp_1h[arr_warp] = 1'b1;
    live_need = SUM_W'($countones(~warp_exit)) * SUM_W'(WARP_SIZE);
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_slot
    assign slot_hit[b] = arr_valid && !req_bad && (sel_id == ID_W'(b));
    nb_slot #(
      .NUM_WARPS(NUM_WARPS), .WARP_SIZE(WARP_SIZE), .SUM_W(SUM_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .hit(slot_hit[b]),
      .req_mode(req_mode), .req_need(SUM_W'(req_need)),
      .req_warp_1h(warp_1h), .live_need(live_need),
      .done(slot_done[b]), .waiting(slot_wait[b]), .clash(slot_clash[b])
    );
  end

  always_comb begin
    rel_d = '0;
    for (int b = 0; b < NUM_BARS; b++)
      if (slot_done[b]) rel_d = rel_d | slot_wait[b];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      release_warps    <= '0;
      err_not_multiple <= 1'b0;
      err_count_clash  <= 1'b0;
    end else begin
      release_warps    <= rel_d;
      err_not_multiple <= arr_valid && req_bad;
      err_count_clash  <= |slot_clash;
    end
  end

  // R3: a count that is not a whole number of warps is flagged next cycle
  p_bad_count_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_valid && arr_cnt_given && ((arr_thr_cnt % CNT_W'(WARP_SIZE)) != '0) |=> err_not_multiple);
  // R9: a clash flag always traces back to a request beat
  p_clash_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_count_clash |-> $past(arr_valid));
  // R10: the request port never stalls
  p_always_ready_r10: assert property (@(posedge clk) disable iff (!rst_n) arr_ready);
  // R7: at most one barrier reacts to a single arrival
  p_single_target_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(slot_hit));
endmodule

// File: tb/sim_nb_barrier_unit.sv
module sim_nb_barrier_unit;
  localparam int NB = 16, NW = 4, WS = 32;
  localparam int ID_W = $clog2(NB), WID_W = $clog2(NW), CNT_W = $clog2(NW*WS+1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic arr_valid = 0, arr_ready, arr_id_given = 0, arr_cnt_given = 0;
  logic [ID_W-1:0] arr_bar_id = '0;
  logic [CNT_W-1:0] arr_thr_cnt = '0;
  logic [WID_W-1:0] arr_warp = '0;
  logic [NW-1:0] warp_exit = '0, release_warps;
  logic err_not_multiple, err_count_clash;
  int errors = 0, checks = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nb_barrier_unit #(.NUM_BARS(NB), .NUM_WARPS(NW), .WARP_SIZE(WS)) u0 (
    .clk(clk), .rst_n(rst_n), .arr_valid(arr_valid), .arr_ready(arr_ready),
    .arr_id_given(arr_id_given), .arr_bar_id(arr_bar_id),
    .arr_cnt_given(arr_cnt_given), .arr_thr_cnt(arr_thr_cnt), .arr_warp(arr_warp),
    .warp_exit(warp_exit), .release_warps(release_warps),
    .err_not_multiple(err_not_multiple), .err_count_clash(err_count_clash));

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drives one beat at a negedge; returns at the next negedge
  task automatic arrive(int id, bit idg, bit cg, int cnt, int w);
    arr_valid = 1; arr_id_given = idg; arr_bar_id = ID_W'(id);
    arr_cnt_given = cg; arr_thr_cnt = CNT_W'(cnt); arr_warp = WID_W'(w);
    @(negedge clk);
    arr_valid = 0;
  endtask

  initial begin
    #(20*100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk("R1 release", int'(release_warps), 0);
    chk("R1 err_mult", int'(err_not_multiple), 0);
    chk("R1 err_clash", int'(err_count_clash), 0);
    rst_n = 1;
    step();
    chk("R10 ready", int'(arr_ready), 1);

    // R2 / R7 sweep: every barrier, every participant count
    for (int b = 0; b < NB; b++) begin
      for (int n = 1; n <= NW; n++) begin
        for (int k = 0; k < n; k++) begin
          arrive(b, 1, 1, n*WS, k);
          chk("R10 ready", int'(arr_ready), 1);
          step();
          if (k < n-1) chk("R2 early", int'(release_warps), 0);
          else         chk("R2 release", int'(release_warps), (1 << n) - 1);
        end
        step();
        chk("R2 pulse", int'(release_warps), 0);
      end
    end

    // R6 + R9 + R4: default id lands on barrier 0, all live warps needed
    for (int k = 0; k < 3; k++) begin
      arrive(7, 0, 0, 0, k);
      step();
      chk("R4 early", int'(release_warps), 0);
    end
    arrive(0, 1, 1, 64, 3);
    chk("R6 R9 clash", int'(err_count_clash), 1);
    step();
    chk("R9 discarded", int'(release_warps), 0);
    arrive(0, 1, 0, 0, 3);
    step();
    chk("R4 release", int'(release_warps), 15);

    // R5: exited warps lower the requirement
    warp_exit = 4'b1000;
    for (int k = 0; k < 3; k++) begin
      arrive(1, 1, 0, 0, k);
      step();
      chk("R5 three live", int'(release_warps), k == 2 ? 7 : 0);
    end
    arrive(1, 1, 0, 0, 0);
    arrive(1, 1, 0, 0, 1);
    step();
    chk("R5 wait", int'(release_warps), 0);
    warp_exit = 4'b1100;
    step();
    chk("R5 exit completes", int'(release_warps), 3);
    warp_exit = '0;
    step();

    // R8: arrival in the completing cycle joins the next use
    arrive(2, 1, 1, 64, 0);
    arrive(2, 1, 1, 64, 1);
    arrive(2, 1, 1, 64, 2);
    chk("R8 old use", int'(release_warps), 3);
    arrive(2, 1, 1, 64, 3);
    step();
    chk("R8 new use", int'(release_warps), 12);

    // R7: two barriers interleaved
    arrive(3, 1, 1, 64, 0);
    arrive(4, 1, 1, 64, 1);
    arrive(3, 1, 1, 64, 2);
    step();
    chk("R7 bar3", int'(release_warps), 5);
    arrive(4, 1, 1, 64, 3);
    step();
    chk("R7 bar4", int'(release_warps), 10);

    // R3: bad counts flagged and discarded
    arrive(5, 1, 1, 48, 0);
    chk("R3 not multiple", int'(err_not_multiple), 1);
    arrive(5, 1, 1, 0, 3);
    chk("R3 zero", int'(err_not_multiple), 1);
    arrive(5, 1, 1, 64, 1);
    chk("R3 flag drops", int'(err_not_multiple), 0);
    step();
    chk("R3 not counted", int'(release_warps), 0);
    arrive(5, 1, 1, 64, 2);
    step();
    chk("R3 release", int'(release_warps), 6);
    chk("R3 no clash", int'(err_count_clash), 0);

    // R9: differing explicit count on a busy barrier
    arrive(6, 1, 1, 64, 0);
    arrive(6, 1, 1, 96, 1);
    chk("R9 clash", int'(err_count_clash), 1);
    arrive(6, 1, 1, 64, 2);
    chk("R9 clear", int'(err_count_clash), 0);
    step();
    chk("R9 release", int'(release_warps), 5);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule